// File: doc/BRIEF.md
# Character display host register interface

This block is the register front end that a microcontroller talks to on a character display controller. Each host access is one clock cycle with the enable strobe high. Two select inputs and a read/write input pick the target: a write-only instruction register, a write-only expansion register, or a data register. The instruction register can also be read, and that read returns a status byte. One of the four select combinations deselects the block.

An address counter points into one of three internal synchronous memories: display data, character generator and auxiliary. The host loads the counter through an instruction or expansion write. The block then prefetches the addressed byte into the data register. Each data write stores the byte at the counter, and each data read returns the prefetched byte. After either one the counter moves on and the data register is reloaded from the new location. A busy flag covers every internal transfer, and any access that arrives while the flag is set is dropped.

Top module: `chd_host_regif`

## Requirements
- R1: Decoding of an access while `en` is high. `sel_a`=1 with `sel_b`=1 targets the data register. `sel_a`=0 with `sel_b`=1 targets the instruction register. `sel_a`=0 with `sel_b`=0 targets the expansion register. `sel_a`=1 with `sel_b`=0 is deselected. `rd`=1 means read and `rd`=0 means write.
- R2: A read of the instruction register asserts `rdata_oe` and returns a status byte: bit 7 is the busy flag and bits 6:0 are the address counter. While busy, bits 6:0 show the raw counter value.
- R3: An expansion-register read and a deselected read keep `rdata_oe` low with `rdata` at 0. A deselected write changes no counter, memory or busy state.
- R4: An instruction write with bit 7 set selects display memory and loads the counter from bits 6:0. A value at or above DD_DEPTH loads 0. An instruction write with bits 7:6 = 01 selects character memory and loads the counter from bits 5:0, with the same rule against CG_DEPTH. An instruction write with bits 7:6 = 00 is ignored and does not set busy.
- R5: An expansion write with bit 7 set selects auxiliary memory and loads the counter from bits 6:0. A value at or above AUX_DEPTH loads 0. An expansion write with bit 7 clear is ignored.
- R6: After any accepted address load, the data register holds the addressed byte by the time busy clears. The next data read returns that byte.
- R7: A data write stores `wdata` at the counter location of the selected memory, then advances the counter.
- R8: A data read returns the data register contents, advances the counter and reloads the data register from the new location.
- R9: Counter advance wraps to 0 after the last location of the selected memory.
- R10: Every accepted access (address load, data write, data read) sets busy for exactly BUSY_CYC cycles, starting with the cycle after the access.
- R11: While busy, instruction, expansion and data writes and data reads change no counter, memory or data register state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Single-cycle access strobe |
| sel_a | input | 1 | First register select |
| sel_b | input | 1 | Second register select |
| rd | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not driven |
| rdata_oe | output | 1 | Read data bus drive enable |

## Verification
The hardest state to reach is an access that arrives during the busy window. A correct host would never issue one, and the window is only a few cycles long. The stimulus reaches it by issuing a second access in the cycle right after an accepted one, for both directed and random cases. It then waits for idle and reads back the counter and the affected memory location, to show that nothing changed. The exact length of the busy window is checked with status reads on consecutive cycles.

// File: rtl/chd_pkg.sv
package chd_pkg;
    localparam int DW   = 8;
    localparam int AC_W = 7;
    localparam int NMEM = 3;

    typedef enum logic [1:0] {
        MEM_DD  = 2'd0,
        MEM_CG  = 2'd1,
        MEM_AUX = 2'd2
    } mem_sel_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IR_WR,
        ACC_STATUS_RD,
        ACC_DR_WR,
        ACC_DR_RD,
        ACC_ER_WR,
        ACC_QUIET
    } acc_e;

    typedef struct packed {
        logic [AC_W-1:0] ac;
        mem_sel_e        sel;
        logic [DW-1:0]   dr;
        logic            fetch_req;
        logic            fetch_wait;
    } regif_st_t;
endpackage

// File: rtl/chd_decode.sv
module chd_decode
    import chd_pkg::*;
(
    input  logic en,
    input  logic sel_a,
    input  logic sel_b,
    input  logic rd,
    output acc_e acc,
    output logic drive
);
    always_comb begin
        acc = ACC_NONE;
        if (en) begin
            unique case ({sel_a, sel_b})
                2'b11:   acc = rd ? ACC_DR_RD : ACC_DR_WR;
                2'b01:   acc = rd ? ACC_STATUS_RD : ACC_IR_WR;
                2'b00:   acc = rd ? ACC_QUIET : ACC_ER_WR;
                default: acc = ACC_QUIET;
            endcase
        end
        drive = (acc == ACC_DR_RD) || (acc == ACC_STATUS_RD);
    end
endmodule

// File: rtl/chd_busy.sv
module chd_busy #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(BUSY_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R10
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R10
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (int'(cnt_q) == BUSY_CYC));
endmodule

// File: rtl/chd_mem.sv
module chd_mem
    import chd_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AC_W-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic            re,
    input  logic [AC_W-1:0] raddr,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] arr_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            arr_q[waddr] <= wdata;
        if (re && (int'(raddr) < DEPTH))
            rdata_q <= arr_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/chd_host_regif.sv
module chd_host_regif
    import chd_pkg::*;
#(
    parameter int DD_DEPTH  = 80,
    parameter int CG_DEPTH  = 64,
    parameter int AUX_DEPTH = 16,
    parameter int BUSY_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdata_oe
);
    initial begin
        cfg_busy_chk: assert (BUSY_CYC >= 3);
        cfg_depth_chk: assert (DD_DEPTH <= 128 && CG_DEPTH <= 64 && AUX_DEPTH <= 128);
    end

    acc_e          acc;
    logic          drive;
    logic          busy;
    logic          accept;
    regif_st_t     st_d, st_q;
    logic [NMEM-1:0] we_vec, re_vec;
    logic [DW-1:0] mem_rd [NMEM];

    function automatic int depth_of(mem_sel_e s);
        case (s)
            MEM_DD:  return DD_DEPTH;
            MEM_CG:  return CG_DEPTH;
            default: return AUX_DEPTH;
        endcase
    endfunction

    function automatic logic [AC_W-1:0] clip(logic [AC_W-1:0] a, int depth);
        return (int'(a) < depth) ? a : '0;
    endfunction

    chd_decode u_dec (
        .en    (en),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .rd    (rd),
        .acc   (acc),
        .drive (drive)
    );

    chd_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy)
    );

    for (genvar g = 0; g < NMEM; g++) begin : g_mem
        localparam int D = (g == 0) ? DD_DEPTH : ((g == 1) ? CG_DEPTH : AUX_DEPTH);
        chd_mem #(.DEPTH(D)) u_mem (
            .clk   (clk),
            .we    (we_vec[g]),
            .waddr (st_q.ac),
            .wdata (wdata),
            .re    (re_vec[g]),
            .raddr (st_q.ac),
            .rdata (mem_rd[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        we_vec = '0;
        re_vec = '0;
        accept = 1'b0;

        if (!busy) begin
            unique case (acc)
                ACC_IR_WR: begin
                    if (wdata[7]) begin
                        st_d.sel = MEM_DD;
                        st_d.ac  = clip(wdata[6:0], DD_DEPTH);
                        accept   = 1'b1;
                    end else if (wdata[6]) begin
                        st_d.sel = MEM_CG;
                        st_d.ac  = clip({1'b0, wdata[5:0]}, CG_DEPTH);
                        accept   = 1'b1;
                    end
                end
                ACC_ER_WR: begin
                    if (wdata[7]) begin
                        st_d.sel = MEM_AUX;
                        st_d.ac  = clip(wdata[6:0], AUX_DEPTH);
                        accept   = 1'b1;
                    end
                end
                ACC_DR_WR, ACC_DR_RD: begin
                    if (acc == ACC_DR_WR)
                        we_vec[st_q.sel] = 1'b1;
                    if (int'(st_q.ac) + 1 >= depth_of(st_q.sel))
                        st_d.ac = '0;
                    else
                        st_d.ac = st_q.ac + 1'b1;
                    accept = 1'b1;
                end
                default: ;
            endcase
        end

        if (accept)
            st_d.fetch_req = 1'b1;

        if (st_q.fetch_req) begin
            re_vec[st_q.sel] = 1'b1;
            st_d.fetch_req   = 1'b0;
            st_d.fetch_wait  = 1'b1;
        end

        if (st_q.fetch_wait) begin
            st_d.dr         = mem_rd[st_q.sel];
            st_d.fetch_wait = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ac: '0, sel: MEM_DD, dr: '0, fetch_req: 1'b0, fetch_wait: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (acc == ACC_STATUS_RD)
            rdata = {busy, st_q.ac};
        else if (acc == ACC_DR_RD)
            rdata = st_q.dr;
    end
    assign rdata_oe = drive;

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((sel_a && !sel_b) || (!sel_a && !sel_b && rd))) |-> !rdata_oe);
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(st_q.ac) && $stable(st_q.sel)));
    // R11
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec != '0) |-> !busy);
    // R9
    ac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.ac) < depth_of(st_q.sel));
    // R7
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));
endmodule

// File: tb/chd_host_regif_tb.sv
`timescale 1ns/1ps
module chd_host_regif_tb_top;
    localparam int DD  = 80;
    localparam int CG  = 64;
    localparam int AUX = 16;
    localparam int BC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, sel_a = 1'b0, sel_b = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    always #2 clk = ~clk;

    chd_host_regif #(.DD_DEPTH(DD), .CG_DEPTH(CG), .AUX_DEPTH(AUX), .BUSY_CYC(BC)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .sel_a(sel_a), .sel_b(sel_b),
        .rd(rd), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int         m_sel;
    int         m_ac;
    logic [7:0] m_dr;
    logic [7:0] m_mem [3][128];

    function automatic int depth_of(int s);
        return (s == 0) ? DD : ((s == 1) ? CG : AUX);
    endfunction

    function automatic int clip(int a, int d);
        return (a < d) ? a : 0;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic access(input bit a, input bit b, input bit r, input logic [7:0] d,
                          output logic [7:0] q, output logic oe);
        @(negedge clk);
        en = 1'b1; sel_a = a; sel_b = b; rd = r; wdata = d;
        #1;
        q = rdata; oe = rdata_oe;
        @(posedge clk);
        #1 en = 1'b0;
    endtask

    task automatic status(output logic [7:0] q);
        logic oe;
        access(1'b0, 1'b1, 1'b1, 8'h00, q, oe);
    endtask

    task automatic wait_idle();
        logic [7:0] q;
        for (int i = 0; i < 30; i++) begin
            status(q);
            if (!q[7]) return;
        end
        chk("R10 idle", q, {1'b0, q[6:0]});
    endtask

    task automatic prefetch();
        m_dr = m_mem[m_sel][m_ac];
    endtask

    task automatic step_ac();
        m_ac = (m_ac + 1 >= depth_of(m_sel)) ? 0 : m_ac + 1;
    endtask

    // Model of an accepted access; returns 1 if it sets busy.
    function automatic bit model_op(int kind, logic [7:0] d);
        case (kind)
            0: begin
                if (d[7]) begin m_sel = 0; m_ac = clip(int'(d[6:0]), DD); end
                else if (d[6]) begin m_sel = 1; m_ac = clip(int'(d[5:0]), CG); end
                else return 0;
            end
            1: begin
                if (d[7]) begin m_sel = 2; m_ac = clip(int'(d[6:0]), AUX); end
                else return 0;
            end
            2: begin m_mem[m_sel][m_ac] = d; m_ac = (m_ac + 1 >= depth_of(m_sel)) ? 0 : m_ac + 1; end
            default: m_ac = (m_ac + 1 >= depth_of(m_sel)) ? 0 : m_ac + 1;
        endcase
        m_dr = m_mem[m_sel][m_ac];
        return 1;
    endfunction

    // kind: 0 IR write, 1 ER write, 2 DR write, 3 DR read
    task automatic issue(int kind, logic [7:0] d, output logic [7:0] q, output logic oe);
        case (kind)
            0: access(1'b0, 1'b1, 1'b0, d, q, oe);
            1: access(1'b0, 1'b0, 1'b0, d, q, oe);
            2: access(1'b1, 1'b1, 1'b0, d, q, oe);
            default: access(1'b1, 1'b1, 1'b1, d, q, oe);
        endcase
    endtask

    task automatic do_op(int kind, logic [7:0] d, string req);
        logic [7:0] q;
        logic oe;
        logic [7:0] exp_dr;
        bit b;
        exp_dr = m_dr;
        issue(kind, d, q, oe);
        if (kind == 3) chk({req, " R8 dr read"}, q, exp_dr);
        b = model_op(kind, d);
        wait_idle();
    endtask

    task automatic check_status(string req);
        logic [7:0] q;
        status(q);
        chk(req, q, {1'b0, 7'(m_ac)});
    endtask

    task automatic fill(int s);
        if (s == 2) do_op(1, 8'h80, "R5");
        else        do_op(0, (s == 0) ? 8'h80 : 8'h40, "R4");
        for (int i = 0; i < depth_of(s); i++)
            do_op(2, 8'((i * 37 + s * 11 + 5) & 8'hFF), "R7");
        check_status("R9 wrap after fill");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic oe;
        void'($urandom(32'd4711));
        m_sel = 0; m_ac = 0; m_dr = '0;
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 128; i++) m_mem[s][i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset status
        access(1'b0, 1'b1, 1'b1, 8'h00, q, oe);
        chk("R2 reset status", q, 8'h00);
        chk("R2 status oe", {7'd0, oe}, 8'h01);

        // R4 R5 R7 R9 fill all memories
        fill(0); fill(1); fill(2);

        // R10 exact busy window
        issue(0, 8'h85, q, oe);
        begin bit b; b = model_op(0, 8'h85); end
        for (int i = 0; i < BC; i++) begin
            status(q);
            chk("R10 busy window", q, 8'h85);
        end
        status(q);
        chk("R10 busy cleared", q, 8'h05);

        // R6 prefetch, R8 reload
        do_op(3, 8'h00, "R6");
        do_op(3, 8'h00, "R8");
        check_status("R8 ac advance");

        // R11 ignored address load while busy
        issue(0, 8'h8A, q, oe);
        begin bit b; b = model_op(0, 8'h8A); end
        issue(0, 8'h80, q, oe);
        wait_idle();
        check_status("R11 ignored ir");

        // R11 ignored data write while busy
        issue(0, 8'hC3, q, oe);
        begin bit b; b = model_op(0, 8'hC3); end
        issue(2, 8'h5A, q, oe);
        wait_idle();
        do_op(3, 8'h00, "R11 ignored dr wr");

        // R3 quiet reads and deselected write
        access(1'b0, 1'b0, 1'b1, 8'h00, q, oe);
        chk("R3 er read oe", {7'd0, oe}, 8'h00);
        chk("R3 er read data", q, 8'h00);
        access(1'b1, 1'b0, 1'b1, 8'h00, q, oe);
        chk("R3 desel read oe", {7'd0, oe}, 8'h00);
        access(1'b1, 1'b0, 1'b0, 8'h81, q, oe);
        check_status("R3 desel write");

        // R4 ignored code, no busy
        access(1'b0, 1'b1, 1'b0, 8'h12, q, oe);
        check_status("R4 code 00 ignored");

        // R5 ignored expansion code
        access(1'b0, 1'b0, 1'b0, 8'h7F, q, oe);
        check_status("R5 code 0 ignored");

        // R5 R9 aux top address and wrap
        do_op(1, 8'h8F, "R5");
        check_status("R5 aux addr");
        do_op(3, 8'h00, "R9");
        check_status("R9 aux wrap");

        // R4 out-of-range display address
        do_op(0, 8'hD0, "R4");
        check_status("R4 out of range");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int kind;
            logic [7:0] d;
            logic [7:0] exp_dr;
            bit acc;
            kind = int'($urandom_range(0, 5));
            d = 8'($urandom);
            if (kind <= 3) begin
                exp_dr = m_dr;
                issue(kind, d, q, oe);
                if (kind == 3) chk("R8 random dr read", q, exp_dr);
                acc = model_op(kind, d);
                if (acc && ($urandom_range(0, 3) == 0)) begin
                    int k2;
                    k2 = int'($urandom_range(0, 3));
                    issue(k2, 8'($urandom), q, oe);
                end
                wait_idle();
            end else if (kind == 4) begin
                check_status("R2 random status");
            end else begin
                access(1'b1, 1'b0, d[0], d, q, oe);
                chk("R3 random desel oe", {7'd0, oe}, 8'h00);
            end
            if ((it % 16) == 0) check_status("R1 random ac");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule